// File: doc/BRIEF.md
# Line-Split Byte-Enable Generator

This block sits between the address stage of a load/store unit and a level-one data cache whose lines are 16 bytes wide and whose write columns take one enable per byte. It accepts one memory access per cycle: a byte address, a width code for 1, 2, 4 or 8 bytes, a load/store flag and, for stores, up to 64 bits of data. It emits one cache-facing bundle. The bundle holds a first line request and, when the access runs past the end of its line, a second request for the next line that carries the overflow bytes.

The byte offset inside the line and the access width are expanded into a 16-bit enable mask for each request. Store data is rotated so that each byte sits in the lane its enable bit names. Loads carry no data. Instead, each request returns the byte offset, so that a consumer can rotate the one or two returned lines back into register order. A single output register stage holds the bundle, and a valid/ready handshake on both sides lets a stalled cache freeze the result.

Top module: `lsm_line_splitter`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is low. With `out_valid` low, `req_ready` is high.
- R2: The width code `req_size` means 00 = 1 byte, 01 = 2, 10 = 4 and 11 = 8. The two masks together hold exactly that many set bits.
- R3: `out_line0` equals `req_addr[ADDR_W-1:4]`. Bit p of `out_mask0` is set exactly when p = offset + k for some byte k of the access with p < 16, where offset = `req_addr[3:0]`.
- R4: When offset + bytes exceeds 16, `out_second` is high. `out_mask1` bit (offset + k − 16) is set for each byte k that overflows, and `out_line1` equals `out_line0 + 1`, wrapping at the top of the address space.
- R5: When the access fits inside its line, `out_second` is low and `out_mask1` is all zeros.
- R6: For a store, byte k of `req_wdata` (bits 8k+7:8k) appears in lane offset + k of `out_data0` when that lane is below 16, and otherwise in lane offset + k − 16 of `out_data1`. Every lane not enabled is zero, and `req_wdata` bytes beyond the access width are dropped.
- R7: For a load, `out_data0` and `out_data1` are all zeros. For every access, `out_shift` equals offset.
- R8: A request accepted on a clock edge (`req_valid` and `req_ready` both high) is presented on the outputs from that edge, with `out_valid` high.
- R9: While `out_valid` is high and `out_ready` is low, `req_ready` is low and every output holds its value.
- R10: `out_store` reproduces the `req_store` flag of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take the request this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| req_size | input | 2 | Width code: 00=1, 01=2, 10=4, 11=8 bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, byte 0 in bits 7:0 |
| out_valid | output | 1 | Bundle valid |
| out_ready | input | 1 | Cache side accepts the bundle |
| out_store | output | 1 | Store flag of the bundle |
| out_line0 | output | ADDR_W-4 (28) | Line address of the first request |
| out_mask0 | output | 16 | Byte enables of the first request |
| out_data0 | output | 128 | Lane-aligned store data, first line |
| out_second | output | 1 | Second request is valid |
| out_line1 | output | ADDR_W-4 (28) | Line address of the second request |
| out_mask1 | output | 16 | Byte enables of the second request |
| out_data1 | output | 128 | Lane-aligned store data, second line |
| out_shift | output | 4 | Byte rotation applied (address offset in line) |

## Verification
The checker assumes that `req_size` holds one of the four defined codes and that a request stays stable while it is stalled. It also assumes that `out_ready` is driven on every cycle after reset. The bench sweeps every offset, every width code and both directions on a mid-range line and on the last line of the address space, where the second line address wraps. It changes inputs only at falling edges and keeps a request unchanged while `req_ready` is low. A separate stall sequence holds `out_ready` low with a second request waiting behind the first.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  // Widest access the width code can express, in bytes.
  localparam int ACC_MAX_BYTES = 8;
  localparam int SIZE_W        = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  // Number of bytes named by a width code.
  function automatic int unsigned size_bytes(input logic [SIZE_W-1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/lsm_mask_expand.sv
module lsm_mask_expand
  import lsm_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WIN_W     = 2 * LINE_BYTES
) (
  input  logic [OFF_W-1:0]      offset,
  input  logic [SIZE_W-1:0]     size,
  output logic [LINE_BYTES-1:0] mask_lo,
  output logic [LINE_BYTES-1:0] mask_hi,
  output logic                  spill
);
  logic [WIN_W-1:0] ones;
  logic [WIN_W-1:0] window;

  // One enable per byte of the access, starting at lane 0.
  for (genvar k = 0; k < WIN_W; k++) begin : g_ones
    if (k < ACC_MAX_BYTES) begin : g_live
      assign ones[k] = (k < size_bytes(size));
    end else begin : g_dead
      assign ones[k] = 1'b0;
    end
  end

  always_comb begin
    window  = ones << offset;
    mask_lo = window[LINE_BYTES-1:0];
    mask_hi = window[WIN_W-1:LINE_BYTES];
    spill   = |mask_hi;
  end
endmodule

// File: rtl/lsm_lane_place.sv
module lsm_lane_place
  import lsm_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_BITS = 8 * LINE_BYTES,
  localparam int IN_BITS   = 8 * ACC_MAX_BYTES
) (
  input  logic [OFF_W-1:0]     offset,
  input  logic [SIZE_W-1:0]    size,
  input  logic                 store,
  input  logic [IN_BITS-1:0]   wdata,
  output logic [LINE_BITS-1:0] data_lo,
  output logic [LINE_BITS-1:0] data_hi
);
  logic [IN_BITS-1:0]     trimmed;
  logic [2*LINE_BITS-1:0] rotated;

  // Drop bytes past the access width; loads carry no data.
  for (genvar k = 0; k < ACC_MAX_BYTES; k++) begin : g_trim
    assign trimmed[8*k +: 8] = (store && (k < size_bytes(size))) ? wdata[8*k +: 8] : 8'h00;
  end

  always_comb begin
    rotated = {{(2*LINE_BITS-IN_BITS){1'b0}}, trimmed} << {offset, 3'b000};
    data_lo = rotated[LINE_BITS-1:0];
    data_hi = rotated[2*LINE_BITS-1:LINE_BITS];
  end
endmodule

// File: rtl/lsm_out_stage.sv
module lsm_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsm_line_splitter.sv
module lsm_line_splitter
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int LINE_BITS = 8 * LINE_BYTES,
  localparam int IN_BITS   = 8 * ACC_MAX_BYTES,
  localparam int PW        = 1 + 2*LINE_W + 2*LINE_BYTES + 2*LINE_BITS + 1 + OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic                  req_store,
  input  logic [IN_BITS-1:0]    req_wdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_store,
  output logic [LINE_W-1:0]     out_line0,
  output logic [LINE_BYTES-1:0] out_mask0,
  output logic [LINE_BITS-1:0]  out_data0,
  output logic                  out_second,
  output logic [LINE_W-1:0]     out_line1,
  output logic [LINE_BYTES-1:0] out_mask1,
  output logic [LINE_BITS-1:0]  out_data1,
  output logic [OFF_W-1:0]      out_shift
);
  logic [OFF_W-1:0]      offset;
  logic [LINE_W-1:0]     line_a, line_b;
  logic [LINE_BYTES-1:0] m_lo, m_hi;
  logic [LINE_BITS-1:0]  d_lo, d_hi;
  logic                  spill;
  logic [PW-1:0]         pay_in, pay_out;

  assign offset = req_addr[OFF_W-1:0];
  assign line_a = req_addr[ADDR_W-1:OFF_W];
  assign line_b = line_a + 1'b1;

  lsm_mask_expand #(.LINE_BYTES(LINE_BYTES)) u_mask (
    .offset (offset),
    .size   (req_size),
    .mask_lo(m_lo),
    .mask_hi(m_hi),
    .spill  (spill)
  );

  lsm_lane_place #(.LINE_BYTES(LINE_BYTES)) u_lane (
    .offset (offset),
    .size   (req_size),
    .store  (req_store),
    .wdata  (req_wdata),
    .data_lo(d_lo),
    .data_hi(d_hi)
  );

  assign pay_in = {req_store, line_a, m_lo, d_lo, spill, line_b, m_hi, d_hi, offset};

  lsm_out_stage #(.PW(PW)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (pay_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (pay_out)
  );

  assign {out_store, out_line0, out_mask0, out_data0,
          out_second, out_line1, out_mask1, out_data1, out_shift} = pay_out;
endmodule

// File: rtl/lsm_split_checker.sv
module lsm_split_checker
  import lsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int LINE_BITS = 8 * LINE_BYTES
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [SIZE_W-1:0]     req_size,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_store,
  input logic [LINE_W-1:0]     out_line0,
  input logic [LINE_BYTES-1:0] out_mask0,
  input logic [LINE_BITS-1:0]  out_data0,
  input logic                  out_second,
  input logic [LINE_W-1:0]     out_line1,
  input logic [LINE_BYTES-1:0] out_mask1,
  input logic [LINE_BITS-1:0]  out_data1
);
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) size_q <= '0;
    else if (req_valid && req_ready) size_q <= req_size;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_byte_count_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_mask1, out_mask0}) == size_bytes(size_q));

  p_first_used_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mask0 != '0);

  p_cross_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_second |-> out_mask0[LINE_BYTES-1] && out_mask1[0]
                               && (out_line1 == out_line0 + 1'b1));

  p_fits_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_second |-> out_mask1 == '0);

  p_load_no_data_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_store |-> (out_data0 == '0) && (out_data1 == '0));

  p_accept_shows_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> out_valid);

  p_stall_block_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !req_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mask0) && $stable(out_mask1)
                                && $stable(out_line0) && $stable(out_data0)
                                && $stable(out_data1) && $stable(out_store));
endmodule

bind lsm_line_splitter lsm_split_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_store (out_store),
  .out_line0 (out_line0),
  .out_mask0 (out_mask0),
  .out_data0 (out_data0),
  .out_second(out_second),
  .out_line1 (out_line1),
  .out_mask1 (out_mask1),
  .out_data1 (out_data1)
);

// File: tb/lsm_line_splitter_test.sv
module lsm_line_splitter_test;
  localparam int ADDR_W = 32;
  localparam int LINE_W = ADDR_W - 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_store = 1'b0;
  logic [63:0]   req_wdata = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_store;
  logic [27:0]   out_line0, out_line1;
  logic [15:0]   out_mask0, out_mask1;
  logic [127:0]  out_data0, out_data1;
  logic          out_second;
  logic [3:0]    out_shift;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lsm_line_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(16)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_store(req_store),
    .req_wdata(req_wdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_store(out_store), .out_line0(out_line0), .out_mask0(out_mask0),
    .out_data0(out_data0), .out_second(out_second), .out_line1(out_line1),
    .out_mask1(out_mask1), .out_data1(out_data1), .out_shift(out_shift)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: compute the expected bundle byte by byte.
  task automatic expect_and_check(input logic [27:0] line, input int off, input int sz,
                                  input bit st, input logic [63:0] wd);
    logic [15:0]  m0 = '0, m1 = '0;
    logic [127:0] d0 = '0, d1 = '0;
    int nb = 1 << sz;
    for (int k = 0; k < nb; k++) begin
      int p = off + k;
      if (p < 16) begin
        m0[p] = 1'b1;
        if (st) d0[8*p +: 8] = wd[8*k +: 8];
      end else begin
        m1[p-16] = 1'b1;
        if (st) d1[8*(p-16) +: 8] = wd[8*k +: 8];
      end
    end
    check("R8 out_valid", {127'd0, out_valid}, 128'd1);
    check("R3 line0", {100'd0, out_line0}, {100'd0, line});
    check("R2/R3 mask0", {112'd0, out_mask0}, {112'd0, m0});
    check("R4/R5 second", {127'd0, out_second}, {127'd0, (m1 != 0)});
    check("R4/R5 mask1", {112'd0, out_mask1}, {112'd0, m1});
    if (m1 != 0) check("R4 line1", {100'd0, out_line1}, {100'd0, line + 28'd1});
    check(st ? "R6 data0" : "R7 data0", out_data0, d0);
    check(st ? "R6 data1" : "R7 data1", out_data1, d1);
    check("R7 shift", {124'd0, out_shift}, {124'd0, 4'(off)});
    check("R10 store", {127'd0, out_store}, {127'd0, st});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [27:0] bases [2];
    logic [27:0] bstall;
    bases[0] = 28'h123_4567;
    bases[1] = 28'hFFF_FFFF;

    repeat (3) @(negedge clk);
    check("R1 valid in reset", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {127'd0, out_valid}, 128'd0);
    check("R1 ready when idle", {127'd0, req_ready}, 128'd1);

    // Sweep: every line base, direction, width code and offset.
    for (int b = 0; b < 2; b++) begin
      for (int st = 0; st < 2; st++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int off = 0; off < 16; off++) begin
            logic [63:0] wd;
            wd = 64'h8877_6655_4433_2211 ^ {8{8'(off * 16 + sz * 4 + b)}};
            req_valid = 1'b1;
            req_addr  = {bases[b], 4'(off)};
            req_size  = 2'(sz);
            req_store = st[0];
            req_wdata = wd;
            @(negedge clk);
            expect_and_check(bases[b], off, sz, st[0], wd);
          end
        end
      end
    end

    // Stall: first request held, second waits behind it.
    req_valid = 1'b0;
    @(negedge clk);
    bstall    = 28'h0AB_CDEF;
    out_ready = 1'b0;
    req_valid = 1'b1;
    req_addr  = {bstall, 4'd13};
    req_size  = 2'd2;
    req_store = 1'b1;
    req_wdata = 64'h0102_0304_A1B2_C3D4;
    @(negedge clk);
    expect_and_check(bstall, 13, 2, 1'b1, 64'h0102_0304_A1B2_C3D4);
    req_addr  = {bstall, 4'd0};
    req_size  = 2'd3;
    req_store = 1'b0;
    req_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    #1;
    check("R9 ready low in stall", {127'd0, req_ready}, 128'd0);
    @(negedge clk);
    check("R9 ready low in stall", {127'd0, req_ready}, 128'd0);
    expect_and_check(bstall, 13, 2, 1'b1, 64'h0102_0304_A1B2_C3D4);
    out_ready = 1'b1;
    @(negedge clk);
    expect_and_check(bstall, 0, 3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 valid drops when drained", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule